// File: doc/BRIEF.md
# Flow-Control Next-PC and Stall Unit

This block decides where the program counter goes after a flow-control instruction and for how many extra cycles the fetch stage must wait. On each accepted issue it takes the current word address, a signed word displacement, a status byte and a few condition controls. From these it registers the next word address. It also loads a down-counter with the number of bubble cycles that the instruction costs beyond its first cycle.

It handles five operation classes. A plain step goes to the next word. A relative jump and a relative call both go to PC + k + 1. A conditional branch tests either one status bit or the signed-less-than term (N xor V). A conditional skip passes over the following instruction, which is either one or two words long. All address arithmetic wraps within the program-memory word range. The fetch stage holds off while the stall count is non-zero, and the unit refuses new issues during that time.

Top module: `nxpc_flow_unit`

## Requirements
- R1: While `rst_n` is low, `next_pc` is 0, `pc_valid` is 0 and `stall` is 0. All three keep these values on the first edge after reset is released when no issue is presented.
- R2: An accepted issue with `op` = 1 (relative jump) loads `next_pc` = (`pc` + sign-extended `offset` + 1) modulo 2^PC_W and `stall` = 1.
- R3: An accepted issue with `op` = 2 (relative call) loads the same target as R2 and `stall` = 2.
- R4: An accepted issue with `op` = 3 and `cond_signed` = 0 tests `status[cond_sel]`. The branch is taken when that bit equals `cond_set`. Taken gives the R2 target with `stall` = 1; not taken gives `pc` + 1 with `stall` = 0. Bit 0 is carry, so `cond_sel` = 0 with `cond_set` = 0 is unsigned same-or-higher, and with `cond_set` = 1 it is unsigned lower.
- R5: With `op` = 3 and `cond_signed` = 1, the tested value is `status[2]` xor `status[3]` (N xor V), and `cond_sel` is ignored. `cond_set` = 0 gives signed greater-or-equal; `cond_set` = 1 gives signed less-than. Cost and targets are as in R4.
- R6: An accepted issue with `op` = 4 (skip) behaves as follows. If `skip_true` is 0, it loads `pc` + 1 with `stall` = 0. If `skip_true` is 1 and `next_two_word` is 0, it loads `pc` + 2 with `stall` = 1. If `skip_true` is 1 and `next_two_word` is 1, it loads `pc` + 3 with `stall` = 2.
- R7: An accepted issue with `op` = 0, or with any code from 5 to 7, loads `pc` + 1 with `stall` = 0.
- R8: `pc_valid` is high for exactly the one cycle after an accepted issue. A non-zero `stall` decreases by one on each following edge until it reaches 0.
- R9: An issue presented while `stall` is non-zero is not accepted. `next_pc` keeps its value, `pc_valid` stays 0, and `stall` keeps counting down.
- R10: Every address result wraps modulo 2^PC_W, both for displacements below address 0 and for increments past the top word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue | input | 1 | A flow-control instruction is presented this cycle |
| op | input | 3 | Operation class: 0 step, 1 jump, 2 call, 3 branch, 4 skip |
| pc | input | PC_W | Word address of the current instruction |
| offset | input | OFS_W | Signed word displacement k |
| cond_sel | input | 3 | Status bit index tested by a branch |
| cond_signed | input | 1 | Branch tests N xor V instead of the indexed bit |
| cond_set | input | 1 | Branch is taken when the tested value equals this bit |
| status | input | 8 | Status byte (bit 0 C, 1 Z, 2 N, 3 V) |
| skip_true | input | 1 | Skip condition result |
| next_two_word | input | 1 | The instruction after a skip is two words long |
| next_pc | output | PC_W | Registered next word address |
| pc_valid | output | 1 | One-cycle pulse: `next_pc` was just loaded |
| stall | output | STALL_W | Remaining bubble cycles |

## Verification
Most internal faults show up at the ports within one cycle of an accepted issue. A wrong condition select, polarity or target sum appears as a wrong `next_pc` in the cycle that `pc_valid` pulses. A wrong cost appears as a wrong first `stall` value. A counter that sticks or skips a value shows on the next edge. So does a busy gate that lets an issue through mid-stall, which appears as a spurious `pc_valid` or a changed address. Each case reaches the ports before the stall window ends.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

   typedef enum logic [2:0] {
      OPC_STEP   = 3'd0,
      OPC_JUMP   = 3'd1,
      OPC_CALL   = 3'd2,
      OPC_BRANCH = 3'd3,
      OPC_SKIP   = 3'd4
   } flow_op_e;

   // status bit positions used by the signed comparison term
   localparam int unsigned SB_NEG = 2;
   localparam int unsigned SB_OVF = 3;

   // extra cycles per class (total cycles minus one)
   localparam int unsigned XTRA_JUMP  = 1;
   localparam int unsigned XTRA_CALL  = 2;
   localparam int unsigned XTRA_TAKEN = 1;
   localparam int unsigned XTRA_SKIP1 = 1;
   localparam int unsigned XTRA_SKIP2 = 2;

endpackage

// File: rtl/nxpc_cond_eval.sv
module nxpc_cond_eval #(
   parameter int unsigned SR_W = 8
) (
   input  logic [SR_W-1:0]         status,
   input  logic [$clog2(SR_W)-1:0] sel,
   input  logic                    signed_mode,
   input  logic                    want_set,
   output logic                    hit
);
   import nxpc_pkg::*;

   if (SR_W < 4) begin : g_bad_width
      $error("nxpc_cond_eval: SR_W must hold N and V bits");
   end

   logic tested;

   always_comb begin
      if (signed_mode) tested = status[SB_NEG] ^ status[SB_OVF];
      else             tested = status[sel];
      hit = (tested == want_set);
   end
endmodule

// File: rtl/nxpc_rel_target.sv
module nxpc_rel_target #(
   parameter int unsigned PC_W  = 9,
   parameter int unsigned OFS_W = 12
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFS_W-1:0] ofs,
   output logic [PC_W-1:0]  target
);
   logic [PC_W-1:0] ofs_fit;

   // Pick how the displacement is fitted to the address width.
   if (OFS_W >= PC_W) begin : g_trunc
      // modulo arithmetic: the low bits carry everything that matters
      assign ofs_fit = ofs[PC_W-1:0];
   end else begin : g_sext
      assign ofs_fit = {{(PC_W-OFS_W){ofs[OFS_W-1]}}, ofs};
   end

   assign target = pc + ofs_fit + PC_W'(1);
endmodule

// File: rtl/nxpc_stall_ctr.sv
module nxpc_stall_ctr #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] count,
   output logic             busy
);
   always_ff @(posedge clk) begin
      if (!rst_n)              count <= '0;
      else if (load)           count <= load_val;
      else if (count != '0)    count <= count - CNT_W'(1);
   end

   assign busy = (count != '0);
endmodule

// File: rtl/nxpc_flow_unit.sv
module nxpc_flow_unit #(
   parameter int unsigned PC_W    = 9,
   parameter int unsigned OFS_W   = 12,
   parameter int unsigned STALL_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               issue,
   input  logic [2:0]         op,
   input  logic [PC_W-1:0]    pc,
   input  logic [OFS_W-1:0]   offset,
   input  logic [2:0]         cond_sel,
   input  logic               cond_signed,
   input  logic               cond_set,
   input  logic [7:0]         status,
   input  logic               skip_true,
   input  logic               next_two_word,
   output logic [PC_W-1:0]    next_pc,
   output logic               pc_valid,
   output logic [STALL_W-1:0] stall
);
   import nxpc_pkg::*;

   localparam int unsigned SR_W = 8;

   if (PC_W < 2 || PC_W > 24) begin : g_bad_pc
      $error("nxpc_flow_unit: PC_W out of range");
   end
   if (OFS_W < 2) begin : g_bad_ofs
      $error("nxpc_flow_unit: OFS_W too small");
   end
   if (STALL_W < 2) begin : g_bad_stall
      $error("nxpc_flow_unit: STALL_W cannot hold the call cost");
   end

   logic [PC_W-1:0]    rel_tgt;
   logic [PC_W-1:0]    plus1, plus2, plus3;
   logic               cond_hit;
   logic               busy;
   logic               accept;
   logic [PC_W-1:0]    pc_sel;
   logic [STALL_W-1:0] stall_sel;
   flow_op_e           opc;

   nxpc_rel_target #(.PC_W(PC_W), .OFS_W(OFS_W)) u_tgt (
      .pc     (pc),
      .ofs    (offset),
      .target (rel_tgt)
   );

   nxpc_cond_eval #(.SR_W(SR_W)) u_cond (
      .status      (status),
      .sel         (cond_sel),
      .signed_mode (cond_signed),
      .want_set    (cond_set),
      .hit         (cond_hit)
   );

   assign plus1  = pc + PC_W'(1);
   assign plus2  = pc + PC_W'(2);
   assign plus3  = pc + PC_W'(3);
   assign accept = issue & ~busy;
   assign opc    = flow_op_e'(op);

   always_comb begin
      pc_sel    = plus1;
      stall_sel = '0;
      case (opc)
         OPC_JUMP: begin
            pc_sel    = rel_tgt;
            stall_sel = STALL_W'(XTRA_JUMP);
         end
         OPC_CALL: begin
            pc_sel    = rel_tgt;
            stall_sel = STALL_W'(XTRA_CALL);
         end
         OPC_BRANCH: begin
            if (cond_hit) begin
               pc_sel    = rel_tgt;
               stall_sel = STALL_W'(XTRA_TAKEN);
            end
         end
         OPC_SKIP: begin
            if (skip_true) begin
               if (next_two_word) begin
                  pc_sel    = plus3;
                  stall_sel = STALL_W'(XTRA_SKIP2);
               end else begin
                  pc_sel    = plus2;
                  stall_sel = STALL_W'(XTRA_SKIP1);
               end
            end
         end
         default: begin
            pc_sel    = plus1;
            stall_sel = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         next_pc  <= '0;
         pc_valid <= 1'b0;
      end else begin
         pc_valid <= accept;
         if (accept) next_pc <= pc_sel;
      end
   end

   nxpc_stall_ctr #(.CNT_W(STALL_W)) u_stall (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .load_val (stall_sel),
      .count    (stall),
      .busy     (busy)
   );
endmodule

// File: rtl/nxpc_flow_unit_chk.sv
module nxpc_flow_unit_chk #(
   parameter int unsigned PC_W    = 9,
   parameter int unsigned OFS_W   = 12,
   parameter int unsigned STALL_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               issue,
   input logic [2:0]         op,
   input logic [PC_W-1:0]    pc,
   input logic               skip_true,
   input logic [PC_W-1:0]    next_pc,
   input logic               pc_valid,
   input logic [STALL_W-1:0] stall
);
   logic acc;
   assign acc = issue && (stall == '0);

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |=> (stall == '0 && !pc_valid));

   assert_call_cost_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == 3'd2) |=> (stall == STALL_W'(2)));

   assert_jump_cost_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == 3'd1) |=> (stall == STALL_W'(1)));

   assert_false_skip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && op == 3'd4 && !skip_true) |=>
         (stall == '0 && next_pc == PC_W'($past(pc) + PC_W'(1))));

   assert_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall != '0) |=> (stall == $past(stall) - STALL_W'(1)));

   assert_busy_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (stall != '0) |=> (!pc_valid && $stable(next_pc)));
endmodule

bind nxpc_flow_unit nxpc_flow_unit_chk #(
   .PC_W(PC_W), .OFS_W(OFS_W), .STALL_W(STALL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .issue     (issue),
   .op        (op),
   .pc        (pc),
   .skip_true (skip_true),
   .next_pc   (next_pc),
   .pc_valid  (pc_valid),
   .stall     (stall)
);

// File: tb/nxpc_flow_unit_tb.sv
module nxpc_flow_unit_tb_top;
   localparam int PC_W    = 9;
   localparam int OFS_W   = 12;
   localparam int STALL_W = 2;
   localparam int DEPTH   = 1 << PC_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               issue = 1'b0;
   logic [2:0]         op = '0;
   logic [PC_W-1:0]    pc = '0;
   logic [OFS_W-1:0]   offset = '0;
   logic [2:0]         cond_sel = '0;
   logic               cond_signed = 1'b0;
   logic               cond_set = 1'b0;
   logic [7:0]         status = '0;
   logic               skip_true = 1'b0;
   logic               next_two_word = 1'b0;
   logic [PC_W-1:0]    next_pc;
   logic               pc_valid;
   logic [STALL_W-1:0] stall;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   nxpc_flow_unit #(.PC_W(PC_W), .OFS_W(OFS_W), .STALL_W(STALL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .issue(issue), .op(op), .pc(pc),
      .offset(offset), .cond_sel(cond_sel), .cond_signed(cond_signed),
      .cond_set(cond_set), .status(status), .skip_true(skip_true),
      .next_two_word(next_two_word), .next_pc(next_pc),
      .pc_valid(pc_valid), .stall(stall)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int rel_target(input int p, input int k);
      int t;
      t = (p + k + 1) % DEPTH;
      if (t < 0) t += DEPTH;
      return t;
   endfunction

   // issue one instruction, check result and the countdown that follows
   task automatic run(input string req, input int o, input int p, input int k,
                      input int sel, input bit sgn, input bit setv,
                      input int st, input bit sk, input bit two,
                      input int exp_pc, input int exp_stall);
      @(negedge clk);
      issue = 1'b1; op = 3'(o); pc = PC_W'(p); offset = OFS_W'(k);
      cond_sel = 3'(sel); cond_signed = sgn; cond_set = setv;
      status = 8'(st); skip_true = sk; next_two_word = two;
      @(negedge clk);
      issue = 1'b0;
      check({req, " valid"}, int'(pc_valid), 1);
      check({req, " pc"},    int'(next_pc),  exp_pc);
      check({req, " stall"}, int'(stall),    exp_stall);
      for (int s = exp_stall - 1; s >= 0; s--) begin
         @(negedge clk);
         check({req, " R8 countdown"}, int'(stall), s);
         check({req, " R8 pulse"}, int'(pc_valid), 0);
      end
   endtask

   task automatic t_reset();
      check("R1 pc", int'(next_pc), 0);
      check("R1 valid", int'(pc_valid), 0);
      check("R1 stall", int'(stall), 0);
   endtask

   task automatic t_jump();
      run("R2 fwd", 1, 100, 27, 0, 0, 0, 0, 0, 0, rel_target(100, 27), 1);
      run("R2 back", 1, 100, -40, 0, 0, 0, 0, 0, 0, rel_target(100, -40), 1);
      run("R10 under", 1, 3, -10, 0, 0, 0, 0, 0, 0, rel_target(3, -10), 1);
      run("R10 over", 1, 500, 20, 0, 0, 0, 0, 0, 0, rel_target(500, 20), 1);
   endtask

   task automatic t_call();
      run("R3 call", 2, 200, -1, 0, 0, 0, 0, 0, 0, rel_target(200, -1), 2);
   endtask

   task automatic t_branch();
      // Z (bit 1) set, branch when set -> taken
      run("R4 zset", 3, 50, 5, 1, 0, 1, 8'h02, 0, 0, rel_target(50, 5), 1);
      // Z set, branch when clear -> not taken
      run("R4 zclr", 3, 50, 5, 1, 0, 0, 8'h02, 0, 0, 51, 0);
      // carry 0: same-or-higher taken, lower not
      run("R4 sh", 3, 60, -6, 0, 0, 0, 8'hFE, 0, 0, rel_target(60, -6), 1);
      run("R4 lo", 3, 60, -6, 0, 0, 1, 8'hFE, 0, 0, 61, 0);
      // T bit 6
      run("R4 tbit", 3, 70, 9, 6, 0, 1, 8'h40, 0, 0, rel_target(70, 9), 1);
   endtask

   task automatic t_signed();
      // N=1 V=1 -> xor 0: ge taken, lt not; cond_sel points at a 1 bit (ignored)
      run("R5 ge", 3, 80, 12, 7, 1, 0, 8'h8C, 0, 0, rel_target(80, 12), 1);
      run("R5 lt0", 3, 80, 12, 7, 1, 1, 8'h8C, 0, 0, 81, 0);
      // N=1 V=0 -> xor 1: lt taken, ge not; S bit 4 held 0 (not used)
      run("R5 lt1", 3, 90, -3, 4, 1, 1, 8'h04, 0, 0, rel_target(90, -3), 1);
      run("R5 ge1", 3, 90, -3, 4, 1, 0, 8'h04, 0, 0, 91, 0);
   endtask

   task automatic t_skip();
      run("R6 false", 4, 120, 0, 0, 0, 0, 0, 0, 1, 121, 0);
      run("R6 one", 4, 120, 0, 0, 0, 0, 0, 1, 0, 122, 1);
      run("R6 two", 4, 120, 0, 0, 0, 0, 0, 1, 1, 123, 2);
      run("R10 skipwrap", 4, 510, 0, 0, 0, 0, 0, 1, 1, 1, 2);
   endtask

   task automatic t_step();
      run("R7 step", 0, 511, 33, 0, 0, 0, 0, 1, 1, 0, 0);
      run("R7 code6", 6, 40, 33, 0, 0, 0, 0, 1, 1, 41, 0);
   endtask

   task automatic t_blocked();
      @(negedge clk);
      issue = 1'b1; op = 3'd2; pc = PC_W'(300); offset = OFS_W'(10);
      @(negedge clk);
      check("R9 load pc", int'(next_pc), rel_target(300, 10));
      check("R9 load stall", int'(stall), 2);
      op = 3'd1; pc = PC_W'(5); offset = OFS_W'(100); // still issuing
      @(negedge clk);
      check("R9 valid", int'(pc_valid), 0);
      check("R9 pc held", int'(next_pc), rel_target(300, 10));
      check("R9 stall", int'(stall), 1);
      issue = 1'b0;
      @(negedge clk);
      check("R9 drained", int'(stall), 0);
      check("R9 pc held2", int'(next_pc), rel_target(300, 10));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_jump();
      t_call();
      t_branch();
      t_signed();
      t_skip();
      t_step();
      t_blocked();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule